// File: doc/BRIEF.md
# Serial Byte Boundary Aligner

This block sits behind a 1:8 deserializer on one high-speed data lane. It receives one unaligned 8-bit word per byte-clock cycle. The byte clock is the bit clock divided by four, because the bits are captured on both clock edges. At the start of each high-speed burst, the transmitter sends a one-byte lane sync pattern one byte time before the packet header. The aligner joins the previous word and the current word into a 16-bit window. It looks for the pattern at each of the eight bit offsets of that window. On the first match it captures the offset and locks.

From the cycle after the lock, the block presents one correctly framed byte per cycle and holds its aligned flag high. A burst-enable input frames each burst. While it is low, the lock is cleared and the flag drops. When it rises again, the next burst is searched afresh. A build-time option bypasses alignment, so that raw deserializer words pass straight through.

The data path is a fixed-rate stream with no valid/ready handshake. The deserializer delivers a word every cycle and cannot be stalled, so the block applies no back-pressure. A consumer must take each byte in the cycle it is presented. The aligned flag acts as the valid qualifier for the output byte.

Top module: `bal_byte_aligner`

## Requirements
- R1: After the asynchronous active-low reset, `aligned_sync` is 0 and `aligned_byte` is 0.
- R2: Serial bits are packed LSB-first, so bit 0 of a word is the earliest bit. The sync pattern is 0xB8, which is serial order 0,0,0,1,1,1,0,1. It is searched at every offset k from 0 to 7 of the window {current word, previous word}, where the window slice is bits k+7..k. While `burst_en` is high and no lock exists, a match locks the block.
- R3: The sync byte itself is never presented with `aligned_sync` high. The first byte with the flag high is the byte that immediately follows the sync pattern in the serial stream. It appears one clock edge after the window that completes it.
- R4: After lock, every cycle presents the next consecutive byte of the serial stream, in order and without gaps, until `burst_en` falls.
- R5: Once locked, the offset stays fixed for the rest of the burst. A later 0xB8 in the payload at a different bit offset does not change the framing.
- R6: When `burst_en` is sampled low, `aligned_sync` is low after that clock edge and the lock is cleared. The next burst is then searched afresh and may lock at a different offset.
- R7: A burst that contains no sync pattern never raises `aligned_sync`.
- R8: In aligning mode, `aligned_byte` is 0 in every cycle where `aligned_sync` is low.
- R9: With `BYPASS`=1, `aligned_byte` is the raw input word delayed by one edge, and `aligned_sync` is `burst_en` delayed by one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_en | input | 1 | High during a high-speed burst; low clears the lock |
| raw_word | input | W | Unaligned deserializer word, LSB is the earliest bit |
| aligned_byte | output | W | Framed byte (0 while not aligned) |
| aligned_sync | output | 1 | High while `aligned_byte` carries aligned data |

## Verification
The bench places the sync pattern at each of the eight bit offsets in turn. A design that mis-indexed the window, or searched only some offsets, would frame the payload wrongly or never raise its flag. Some bursts carry a decoy 0xB8 that straddles two payload bytes at another offset. A design that kept searching after lock would jump to that framing in the middle of the burst. The bench checks the first flagged byte against the byte that follows the sync pattern, which catches a design that presents the sync byte or loses one byte of latency. It also checks that the flag drops right after the enable falls, which catches a design whose lock survives between bursts, and that a burst without the pattern never raises the flag.

// File: rtl/bal_pkg.sv
package bal_pkg;
  localparam int unsigned BAL_WORD_W = 8;
  localparam logic [BAL_WORD_W-1:0] BAL_SYNC_PAT = 8'hB8;
endpackage

// File: rtl/bal_window.sv
module bal_window #(
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   din,
  output logic [2*W-1:0] win
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= din;
  end

  // older word in the low half: lower index is earlier in time
  assign win = {din, prev_q};
endmodule

// File: rtl/bal_search.sv
module bal_search #(
  parameter int unsigned W   = 8,
  parameter logic [W-1:0] PAT = 8'hB8,
  localparam int unsigned OW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [2*W-1:0] win,
  output logic           hit,
  output logic [OW-1:0]  hit_off
);
  logic [W-1:0] match;

  for (genvar k = 0; k < W; k++) begin : g_cmp
    assign match[k] = (win[k +: W] == PAT);
  end

  // lowest offset is the earliest occurrence in serial time
  always_comb begin
    hit_off = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (match[k]) hit_off = OW'(k);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/bal_lock.sv
module bal_lock #(
  parameter int unsigned W = 8,
  localparam int unsigned OW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          hit,
  input  logic [OW-1:0] hit_off,
  output logic          locked,
  output logic [OW-1:0] off
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      off    <= '0;
    end else if (!en) begin
      locked <= 1'b0;
      off    <= '0;
    end else if (!locked && hit) begin
      locked <= 1'b1;
      off    <= hit_off;
    end
  end

  // R5: framing frozen while the lock is held
  p_off_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (!locked || $stable(off)));

  // R2: a lock only ever starts from a pattern match in an enabled cycle
  p_lock_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(hit && en));
endmodule

// File: rtl/bal_byte_aligner.sv
module bal_byte_aligner #(
  parameter int unsigned W      = bal_pkg::BAL_WORD_W,
  parameter logic [W-1:0] PAT   = bal_pkg::BAL_SYNC_PAT,
  parameter bit          BYPASS = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         burst_en,
  input  logic [W-1:0] raw_word,
  output logic [W-1:0] aligned_byte,
  output logic         aligned_sync
);
  localparam int unsigned OW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0] byte_q;
  logic         sync_q;

  if (BYPASS) begin : g_raw
    // R9: registered pass-through, flag follows the enable
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
        sync_q <= 1'b0;
      end else begin
        byte_q <= raw_word;
        sync_q <= burst_en;
      end
    end
  end else begin : g_align
    logic [2*W-1:0] win;
    logic           hit;
    logic [OW-1:0]  hit_off;
    logic           lock_q;
    logic [OW-1:0]  off_q;

    bal_window #(.W(W)) u_win (
      .clk(clk), .rst_n(rst_n), .din(raw_word), .win(win)
    );

    bal_search #(.W(W), .PAT(PAT)) u_srch (
      .win(win), .hit(hit), .hit_off(hit_off)
    );

    bal_lock #(.W(W)) u_lock (
      .clk(clk), .rst_n(rst_n), .en(burst_en), .hit(hit),
      .hit_off(hit_off), .locked(lock_q), .off(off_q)
    );

    // the sync byte sits at off_q in the lock cycle; one cycle later the
    // same offset frames the byte that follows it
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
        sync_q <= 1'b0;
      end else if (lock_q && burst_en) begin
        byte_q <= win[off_q +: W];
        sync_q <= 1'b1;
      end else begin
        byte_q <= '0;
        sync_q <= 1'b0;
      end
    end

    // R3: the flag rises only after a lock was already held
    p_sync_needs_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(aligned_sync) |-> $past(lock_q));

    // R8: no stale data while not aligned
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !aligned_sync |-> (aligned_byte == '0));
  end

  assign aligned_byte = byte_q;
  assign aligned_sync = sync_q;

  // R6: dropping the enable removes the flag at the next edge
  p_sync_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_en |=> !aligned_sync);
endmodule

// File: tb/bal_byte_aligner_bench.sv
module bal_byte_aligner_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic       en;
  logic [7:0] raw;
  logic [7:0] a_byte, r_byte;
  logic       a_sync, r_sync;

  bal_byte_aligner u_bal_byte_aligner (
    .clk(clk), .rst_n(rst_n), .burst_en(en), .raw_word(raw),
    .aligned_byte(a_byte), .aligned_sync(a_sync)
  );

  bal_byte_aligner #(.BYPASS(1'b1)) u_bal_byte_aligner_raw (
    .clk(clk), .rst_n(rst_n), .burst_en(en), .raw_word(raw),
    .aligned_byte(r_byte), .aligned_sync(r_sync)
  );

  int checks = 0;
  int errors = 0;
  bit bq[$];
  logic [7:0] pay_q[$];
  int pay_idx;
  int sync_cycles;
  bit decoy;

  // behavioural reference
  logic [7:0] m_prev, m_out, b_out;
  bit m_lock, m_sync, b_sync;
  int m_off;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = 0; m_out = 0; m_lock = 0; m_sync = 0; m_off = 0;
      b_out = 0; b_sync = 0;
    end else begin
      logic [15:0] w;
      bit found;
      w = {raw, m_prev};
      m_sync = m_lock && en;
      m_out = m_sync ? w[m_off +: 8] : 8'h00;
      if (!en) m_lock = 0;
      else if (!m_lock) begin
        found = 0;
        for (int k = 0; k < 8; k++)
          if (!found && w[k +: 8] == 8'hB8) begin
            found = 1; m_lock = 1; m_off = k;
          end
      end
      m_prev = raw;
      b_out = raw;
      b_sync = en;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(a_byte == m_out, "R4/R8 byte vs model", a_byte, m_out);
      chk(a_sync == m_sync, "R2/R6 flag vs model", a_sync, m_sync);
      chk(r_byte == b_out && r_sync == b_sync, "R9 bypass", {r_sync, r_byte}, {b_sync, b_out});
      if (a_sync) begin
        sync_cycles++;
        if (pay_q.size() > 0) begin
          logic [7:0] e;
          e = pay_q.pop_front();
          if (pay_idx == 0)            chk(a_byte == e, "R3 first payload byte", a_byte, e);
          else if (decoy && pay_idx >= 3) chk(a_byte == e, "R5 framing after decoy", a_byte, e);
          else                         chk(a_byte == e, "R4 payload byte", a_byte, e);
          pay_idx++;
        end
      end
    end
  end

  task automatic push_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) bq.push_back(b[i]);
  endtask

  task automatic drive_queue();
    en = 1'b1;
    while (bq.size() > 0) begin
      logic [7:0] w;
      w = 0;
      for (int i = 0; i < 8; i++) w[i] = (bq.size() > 0) ? bq.pop_front() : 1'b0;
      raw = w;
      @(negedge clk);
    end
    en = 1'b0;
    raw = 8'h00;
    @(negedge clk);
  endtask

  task automatic burst(input int k, input bit dec, input int n);
    bq.delete(); pay_q.delete();
    pay_idx = 0; sync_cycles = 0; decoy = dec;
    for (int i = 0; i < 16 + k; i++) bq.push_back(1'b0);
    push_byte(8'hB8);
    for (int i = 0; i < n; i++) begin
      logic [7:0] p;
      p = 8'(8'h11 * (i + 1) + k);
      if (dec && i == 1) p = 8'h80;
      if (dec && i == 2) p = 8'h0B;
      push_byte(p);
      pay_q.push_back(p);
    end
    push_byte(8'h00);
    drive_queue();
    chk(!a_sync, "R6 flag low after enable fell", a_sync, 0);
    chk(sync_cycles > 0, "R2 lock at offset", sync_cycles, k);
    chk(pay_q.size() == 0, "R4 all payload seen", pay_q.size(), 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; raw = 8'h00;
    repeat (3) @(negedge clk);
    chk(a_byte == 0 && a_sync == 0, "R1 reset state", {a_sync, a_byte}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 8; k++) burst(k, k[0], 6);
    burst(3, 1'b1, 10);
    // R7: burst without the pattern
    bq.delete(); pay_q.delete(); sync_cycles = 0;
    for (int i = 0; i < 12; i++) push_byte(i[0] ? 8'h55 : 8'h0F);
    drive_queue();
    chk(sync_cycles == 0, "R7 no pattern no flag", sync_cycles, 0);
    burst(5, 1'b0, 4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule